// File: doc/BRIEF.md
# I2C Controller Status Word Tracker

This block holds the 16-bit status word of an I2C controller that can work as a bus master or as a slave. The bus engine sends it single-cycle event strobes: start, repeated start and stop detection, the end of the acknowledge slot together with the sampled acknowledge level, the start of a master transmission, bus collision, the kind of address match, byte arrival and transfer into the receive holding register, and a host write to the transmit buffer. Each flag follows its own rule for being set and cleared. Some flags are cleared by the hardware, some are cleared by a Stop condition, and some stay set until software clears them.

Software reads the whole word through a combinational read port. It clears the software-owned flags through a write-one-to-clear port. The block also qualifies host writes to the transmit buffer. A write that arrives while the engine is busy is not passed on as a load, and it raises the write collision flag instead. When a flag's set event and its clear event fall in the same cycle, the set event wins, so no hardware event is lost.

Top module: `i2c_stat_tracker`

## Requirements
- R1: After reset, every bit of `stat_word` reads 0.
- R2: Bits 13, 12, 11, 2, 1 and 0 of `stat_word` always read 0.
- R3: Bit 15 (acknowledge status) takes the value of `ack_nack` in the cycle after `ev_ack_end` is high (1 = NACK, 0 = ACK). Without `ev_ack_end` it holds its value.
- R4: Bit 14 (transmit in progress) is set in the cycle after `ev_tx_begin` and cleared in the cycle after `ev_ack_end`.
- R5: Bit 10 (bus collision) is set after `ev_collision`. It stays set until a write-one-to-clear with `clr_data[10]` = 1.
- R6: Bit 9 (general call) is set after `ev_gcall_match`. Bit 8 (10-bit match) is set after `ev_addr10_match`. Both are cleared after `ev_stop`.
- R7: When `host_tx_wr` is high while `eng_busy` is high, `tx_load` stays low and bit 7 (write collision) is set in the next cycle. When `eng_busy` is low, `tx_load` follows `host_tx_wr` and bit 7 is unchanged. Only a write-one-to-clear with `clr_data[7]` = 1 clears bit 7.
- R8: Bit 6 (receive overflow) is set after `rx_xfer` is high while `rx_hold_full` is high. `rx_xfer` alone leaves bit 6 unchanged. Only a write-one-to-clear with `clr_data[6]` = 1 clears bit 6.
- R9: Bit 5 (data/address) is set to 1 after `ev_rx_data` and cleared to 0 after `ev_addr_match`.
- R10: Bit 4 (stop seen) is set after `ev_stop` and cleared after `ev_start` or `ev_rstart`. Bit 3 (start seen) is set after `ev_start` or `ev_rstart` and cleared after `ev_stop`.
- R11: A write-one-to-clear (`clr_en` high) affects only bits 10, 7 and 6. Ones in any other bit of `clr_data` have no effect.
- R12: When a flag's set event and its clear event arrive in the same cycle, the flag is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start | input | 1 | Start condition detected |
| ev_rstart | input | 1 | Repeated start detected |
| ev_stop | input | 1 | Stop condition detected |
| ev_ack_end | input | 1 | End of the slave acknowledge slot in a master transmit |
| ack_nack | input | 1 | Sampled acknowledge level, 1 = NACK |
| ev_tx_begin | input | 1 | Master transmission begins |
| ev_collision | input | 1 | Bus collision during a master operation |
| ev_addr_match | input | 1 | Device address matched |
| ev_gcall_match | input | 1 | General call address matched |
| ev_addr10_match | input | 1 | Second byte of own 10-bit address matched |
| ev_rx_data | input | 1 | Data byte received in slave mode |
| rx_xfer | input | 1 | Shifted byte moves toward the receive holding register |
| rx_hold_full | input | 1 | Receive holding register still unread |
| host_tx_wr | input | 1 | Host write to the transmit buffer |
| eng_busy | input | 1 | Bus engine busy |
| clr_en | input | 1 | Write-one-to-clear strobe |
| clr_data | input | 16 | Write-one-to-clear mask |
| tx_load | output | 1 | Accepted transmit buffer write |
| stat_word | output | 16 | Status word read port |

## Verification
The assertions assume that each event input is a single-cycle strobe and that `ack_nack` is valid whenever `ev_ack_end` is high. They also assume that a rule which expects a flag to be set is not checked while a competing clear of that flag is active, except where set priority is the thing under test. The stimulus drives every input on the falling edge and returns all strobes to 0 after one cycle. For each flag it sweeps every combination of prior value, set event and clear event. It raises only the event lines that belong to the flag under test, so only deliberate conflicts appear.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int unsigned STAT_W = 16;

  localparam int unsigned B_ACK    = 15;
  localparam int unsigned B_TXBSY  = 14;
  localparam int unsigned B_BCOL   = 10;
  localparam int unsigned B_GCALL  = 9;
  localparam int unsigned B_A10    = 8;
  localparam int unsigned B_WCOL   = 7;
  localparam int unsigned B_ROVF   = 6;
  localparam int unsigned B_DATA   = 5;
  localparam int unsigned B_STOP   = 4;
  localparam int unsigned B_START  = 3;

  localparam logic [STAT_W-1:0] SW_CLR_MASK =
    (STAT_W'(1) << B_BCOL) | (STAT_W'(1) << B_WCOL) | (STAT_W'(1) << B_ROVF);

  localparam logic [STAT_W-1:0] IMPL_MASK =
    SW_CLR_MASK | (STAT_W'(1) << B_ACK) | (STAT_W'(1) << B_TXBSY) |
    (STAT_W'(1) << B_GCALL) | (STAT_W'(1) << B_A10) | (STAT_W'(1) << B_DATA) |
    (STAT_W'(1) << B_STOP) | (STAT_W'(1) << B_START);
endpackage

// File: rtl/i2c_stat_flag.sv
module i2c_stat_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;
  logic q_d;
  logic en;

  // Set has priority over clear.
  always_comb begin
    en  = set_i | clr_i;
    q_d = set_i ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_q <= 1'b0;
    else if (en) q_q <= q_d;
  end

  assign q_o = q_q;

  p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  p_clr_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/i2c_stat_decode.sv
module i2c_stat_decode
  import i2c_stat_pkg::*;
(
  input  logic              ev_start,
  input  logic              ev_rstart,
  input  logic              ev_stop,
  input  logic              ev_ack_end,
  input  logic              ack_nack,
  input  logic              ev_tx_begin,
  input  logic              ev_collision,
  input  logic              ev_addr_match,
  input  logic              ev_gcall_match,
  input  logic              ev_addr10_match,
  input  logic              ev_rx_data,
  input  logic              rx_xfer,
  input  logic              rx_hold_full,
  input  logic              host_tx_wr,
  input  logic              eng_busy,
  input  logic              clr_en,
  input  logic [STAT_W-1:0] clr_data,
  output logic [STAT_W-1:0] set_vec,
  output logic [STAT_W-1:0] clr_vec,
  output logic              tx_load
);
  logic any_start;
  logic [STAT_W-1:0] sw_clr;

  always_comb begin
    any_start = ev_start | ev_rstart;
    sw_clr    = clr_en ? (clr_data & SW_CLR_MASK) : '0;
    tx_load   = host_tx_wr & ~eng_busy;

    set_vec = '0;
    clr_vec = sw_clr;

    set_vec[B_ACK]   = ev_ack_end & ack_nack;
    clr_vec[B_ACK]   = ev_ack_end & ~ack_nack;

    set_vec[B_TXBSY] = ev_tx_begin;
    clr_vec[B_TXBSY] = ev_ack_end;

    set_vec[B_BCOL]  = ev_collision;

    set_vec[B_GCALL] = ev_gcall_match;
    clr_vec[B_GCALL] = ev_stop;

    set_vec[B_A10]   = ev_addr10_match;
    clr_vec[B_A10]   = ev_stop;

    set_vec[B_WCOL]  = host_tx_wr & eng_busy;

    set_vec[B_ROVF]  = rx_xfer & rx_hold_full;

    set_vec[B_DATA]  = ev_rx_data;
    clr_vec[B_DATA]  = ev_addr_match;

    set_vec[B_STOP]  = ev_stop;
    clr_vec[B_STOP]  = any_start;

    set_vec[B_START] = any_start;
    clr_vec[B_START] = ev_stop;
  end
endmodule

// File: rtl/i2c_stat_tracker.sv
module i2c_stat_tracker
  import i2c_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              ev_rstart,
  input  logic              ev_stop,
  input  logic              ev_ack_end,
  input  logic              ack_nack,
  input  logic              ev_tx_begin,
  input  logic              ev_collision,
  input  logic              ev_addr_match,
  input  logic              ev_gcall_match,
  input  logic              ev_addr10_match,
  input  logic              ev_rx_data,
  input  logic              rx_xfer,
  input  logic              rx_hold_full,
  input  logic              host_tx_wr,
  input  logic              eng_busy,
  input  logic              clr_en,
  input  logic [STAT_W-1:0] clr_data,
  output logic              tx_load,
  output logic [STAT_W-1:0] stat_word
);
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] stat_q;

  i2c_stat_decode u_dec (
    .ev_start        (ev_start),
    .ev_rstart       (ev_rstart),
    .ev_stop         (ev_stop),
    .ev_ack_end      (ev_ack_end),
    .ack_nack        (ack_nack),
    .ev_tx_begin     (ev_tx_begin),
    .ev_collision    (ev_collision),
    .ev_addr_match   (ev_addr_match),
    .ev_gcall_match  (ev_gcall_match),
    .ev_addr10_match (ev_addr10_match),
    .ev_rx_data      (ev_rx_data),
    .rx_xfer         (rx_xfer),
    .rx_hold_full    (rx_hold_full),
    .host_tx_wr      (host_tx_wr),
    .eng_busy        (eng_busy),
    .clr_en          (clr_en),
    .clr_data        (clr_data),
    .set_vec         (set_vec),
    .clr_vec         (clr_vec),
    .tx_load         (tx_load)
  );

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_flag
      i2c_stat_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec[i]),
        .clr_i (clr_vec[i]),
        .q_o   (stat_q[i])
      );
    end else begin : g_none
      assign stat_q[i] = 1'b0;
    end
  end

  assign stat_word = stat_q;

  p_unimpl_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word & ~IMPL_MASK) == '0);
  p_ack_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack_end |=> stat_word[B_ACK] == $past(ack_nack));
  p_txbusy_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_begin |=> stat_word[B_TXBSY]);
  p_bcol_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[B_BCOL] && !(clr_en && clr_data[B_BCOL])) |=> stat_word[B_BCOL]);
  p_gcall_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && !ev_gcall_match) |=> !stat_word[B_GCALL]);
  p_wcol_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_tx_wr && eng_busy) |-> !tx_load);
  p_wcol_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_tx_wr && eng_busy) |=> stat_word[B_WCOL]);
  p_rovf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_xfer && rx_hold_full) |=> stat_word[B_ROVF]);
  p_data_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_data |=> stat_word[B_DATA]);
  p_stop_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> stat_word[B_STOP]);
  p_keep_hw_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && $countones(set_vec) == 0 && !ev_stop && !ev_ack_end &&
     !ev_addr_match && !ev_start && !ev_rstart)
    |=> (stat_word & ~SW_CLR_MASK) == ($past(stat_word) & ~SW_CLR_MASK));
endmodule

// File: tb/i2c_stat_tracker_tb.sv
module i2c_stat_tracker_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic ev_start, ev_rstart, ev_stop, ev_ack_end, ack_nack, ev_tx_begin;
  logic ev_collision, ev_addr_match, ev_gcall_match, ev_addr10_match;
  logic ev_rx_data, rx_xfer, rx_hold_full, host_tx_wr, eng_busy, clr_en;
  logic [15:0] clr_data;
  logic tx_load;
  logic [15:0] stat_word;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  i2c_stat_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_rstart(ev_rstart),
    .ev_stop(ev_stop), .ev_ack_end(ev_ack_end), .ack_nack(ack_nack),
    .ev_tx_begin(ev_tx_begin), .ev_collision(ev_collision),
    .ev_addr_match(ev_addr_match), .ev_gcall_match(ev_gcall_match),
    .ev_addr10_match(ev_addr10_match), .ev_rx_data(ev_rx_data),
    .rx_xfer(rx_xfer), .rx_hold_full(rx_hold_full), .host_tx_wr(host_tx_wr),
    .eng_busy(eng_busy), .clr_en(clr_en), .clr_data(clr_data),
    .tx_load(tx_load), .stat_word(stat_word)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ev_start = 0; ev_rstart = 0; ev_stop = 0; ev_ack_end = 0; ack_nack = 0;
    ev_tx_begin = 0; ev_collision = 0; ev_addr_match = 0; ev_gcall_match = 0;
    ev_addr10_match = 0; ev_rx_data = 0; rx_xfer = 0; rx_hold_full = 0;
    host_tx_wr = 0; eng_busy = 0; clr_en = 0; clr_data = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  // Drive the set and clear events that belong to one flag.
  task automatic drive(int idx, bit s, bit c);
    case (idx)
      14: begin ev_tx_begin = s; ev_ack_end = c; end
      10: begin ev_collision = s; if (c) begin clr_en = 1; clr_data = 16'h0400; end end
      9:  begin ev_gcall_match = s; ev_stop = c; end
      8:  begin ev_addr10_match = s; ev_stop = c; end
      7:  begin host_tx_wr = s; eng_busy = s; if (c) begin clr_en = 1; clr_data = 16'h0080; end end
      6:  begin rx_xfer = s; rx_hold_full = s; if (c) begin clr_en = 1; clr_data = 16'h0040; end end
      5:  begin ev_rx_data = s; ev_addr_match = c; end
      4:  begin ev_stop = s; ev_start = c; end
      default: begin ev_start = s; ev_stop = c; end
    endcase
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int idxs[9] = '{14, 10, 9, 8, 7, 6, 5, 4, 3};
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 reset word", stat_word, 16'h0000);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", stat_word, 16'h0000);

    // R12 and per-flag rules (R4 R5 R6 R7 R8 R9 R10): sweep prior, set, clear
    foreach (idxs[k]) begin
      for (int pre = 0; pre < 2; pre++)
        for (int s = 0; s < 2; s++)
          for (int c = 0; c < 2; c++) begin
            drive(idxs[k], pre[0], !pre[0]);
            step();
            drive(idxs[k], s[0], c[0]);
            step();
            check($sformatf("R12 sweep bit %0d pre%0d s%0d c%0d", idxs[k], pre, s, c),
                  32'(stat_word[idxs[k]]), 32'(s | (pre & ~c)));
            check("R2 unimplemented bits", 32'(stat_word & 16'h3807), 32'h0);
          end
    end

    // R3 acknowledge status
    ev_ack_end = 1; ack_nack = 1; step();
    check("R3 nack loads 1", 32'(stat_word[15]), 1);
    ack_nack = 0; step();
    check("R3 no strobe holds", 32'(stat_word[15]), 1);
    ev_ack_end = 1; ack_nack = 0; step();
    check("R3 ack loads 0", 32'(stat_word[15]), 0);

    // R4 transmit busy across a byte
    ev_tx_begin = 1; step();
    repeat (8) step();
    check("R4 busy during byte", 32'(stat_word[14]), 1);
    ev_ack_end = 1; step();
    check("R4 cleared at ack end", 32'(stat_word[14]), 0);

    // R10 repeated start
    ev_stop = 1; step();
    check("R10 stop sets bit4", 32'(stat_word[4]), 1);
    check("R10 stop clears bit3", 32'(stat_word[3]), 0);
    ev_rstart = 1; step();
    check("R10 rstart clears bit4", 32'(stat_word[4]), 0);
    check("R10 rstart sets bit3", 32'(stat_word[3]), 1);

    // R7 accepted write when idle
    clr_en = 1; clr_data = 16'h0080; step();
    host_tx_wr = 1; eng_busy = 0; #1;
    check("R7 tx_load when idle", 32'(tx_load), 1);
    step();
    check("R7 no collision when idle", 32'(stat_word[7]), 0);
    host_tx_wr = 1; eng_busy = 1; #1;
    check("R7 write blocked when busy", 32'(tx_load), 0);
    step();
    check("R7 collision set", 32'(stat_word[7]), 1);

    // R8 transfer without full holding register
    clr_en = 1; clr_data = 16'h0040; step();
    rx_xfer = 1; rx_hold_full = 0; step();
    check("R8 no overflow when empty", 32'(stat_word[6]), 0);

    // R5 collision stays until cleared
    ev_collision = 1; step();
    repeat (4) step();
    check("R5 collision sticky", 32'(stat_word[10]), 1);

    // R11 clear-all touches only software flags
    ev_tx_begin = 1; ev_gcall_match = 1; ev_addr10_match = 1; ev_rx_data = 1;
    host_tx_wr = 1; eng_busy = 1; rx_xfer = 1; rx_hold_full = 1; step();
    ev_ack_end = 1; ack_nack = 1; ev_tx_begin = 1; step();
    check("R11 before clear", 32'(stat_word & 16'hC7E0), 32'hC7E0);
    clr_en = 1; clr_data = 16'hFFFF; step();
    check("R11 after clear", 32'(stat_word & 16'hC7E0), 32'hC320);

    // R6 stop clears address flags
    ev_stop = 1; step();
    check("R6 stop clears gcall and 10-bit", 32'(stat_word[9:8]), 0);
    check("R2 unimplemented after run", 32'(stat_word & 16'h3807), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule